// File: doc/BRIEF.md
# Single-Channel Paced Copy Engine

This block is one memory-to-memory copy channel. Software programs a source address, a destination address, a cycle count and a control word through a small word-indexed register port, then sets the enable bit. The engine copies one data unit at a time through a single master port: it reads a unit at the source address and then writes that unit to the destination address. After each unit, each address moves by its own signed step. The master port carries a per-access bus-side select and the unit size.

A cycle is one unit, or four units when burst mode is on. Before each cycle the engine can wait on a request line from a peripheral, chosen separately for the source side and the destination side. It answers with a one-clock grant on that line. When the count runs out, the engine sets a finish flag. When the master port reports an error, it sets an error flag. Either flag drops enable and can drive the interrupt output.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0, `m_req` is 0 and `hs_grant` is all zeros.
- R2: `reg_sel` selects a register: 0 is source address, 1 is destination address, 2 is cycle count and 3 is control. The count holds 24 bits, and its upper 8 bits read as 0. Bit 0 of control is enable, bit 1 finish flag, bit 2 finish interrupt enable, bit 3 burst, bit 4 error flag and bit 5 error interrupt enable. The other control bits read back what was written.
- R3: While enabled with a nonzero count, each unit is one read at the source address followed by one write of the same data at the destination address. The data is right-aligned on `m_rdata`/`m_wdata`, little-endian in memory. Control bits 21:20 give the unit and drive `m_size`: 00 word, 01 half-word, 10 byte, 11 word. `m_addr` holds its value while a request waits for a response.
- R4: The clock edge that accepts the final write of the last cycle sets the finish flag and clears enable. If enable is set while the count is 0, the next edge sets finish and clears enable, and no bus access is made.
- R5: The count register reads the cycles still to go. It drops by one on the edge that accepts the last write of each cycle.
- R6: The source step code is in bits 10:8 and the destination step code is in bits 14:12. After each unit the address changes by 0, +1, +2, +4, -1, -2 or -4 for codes 000, 001, 010, 011, 101, 110 and 111. Code 100 does not step.
- R7: With burst (bit 3) set, one cycle moves four units, so each address moves four times its per-unit step per cycle.
- R8: An error response on the master port sets the error flag and clears enable. The count is left unchanged, and no further request is made.
- R9: `irq` is high while (finish flag and bit 2) or (error flag and bit 5).
- R10: A write of 0 to bit 1 or bit 4 clears that flag. A write of 1 leaves it unchanged.
- R11: The source request number is in bits 27:24 and the destination request number is in bits 19:16. A nonzero number n makes the engine wait before each cycle until `hs_req[n]` is high. The engine then drives `hs_grant[n]` high for exactly one clock, the first clock of that cycle's read. Number 0 means no waiting.
- R12: Clearing enable by a register write stops the channel. No request follows, and the count keeps its value.
- R13: `m_sys` equals control bit 6 during reads and control bit 7 during writes. 1 selects the system bus and 0 the peripheral bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| m_req | output | 1 | Master access request, held until response |
| m_we | output | 1 | Master access is a write |
| m_sys | output | 1 | Bus side of the access (1 system, 0 peripheral) |
| m_size | output | 2 | Unit size code of the access |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Master write data, right-aligned |
| m_rdata | input | 32 | Master read data, right-aligned |
| m_ack | input | 1 | Access completed |
| m_err | input | 1 | Access failed |
| hs_req | input | 16 | Peripheral request lines (line 0 unused) |
| hs_grant | output | 16 | Peripheral grant pulses |
| irq | output | 1 | Interrupt |

## Verification
The bench checks negative and fixed steps on either side, as well as code 100. A wrong step decoder leaves the final addresses off and the copied bytes in the wrong places. It also runs burst cycles with each unit size. If the design counted units instead of cycles, the count would reach zero four times too early. It starts a transfer with a zero count, which a faulty engine would turn into a long run that wraps around. It stalls on a handshake where only one of the two lines is ready, which catches an OR of the two lines where an AND belongs. It also checks that an error or a software stop leaves the count untouched and does not start the next access.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // control word bit positions
  localparam int CB_EN        = 0;
  localparam int CB_FIN       = 1;
  localparam int CB_FIN_IE    = 2;
  localparam int CB_BURST     = 3;
  localparam int CB_ERR       = 4;
  localparam int CB_ERR_IE    = 5;
  localparam int CB_SRC_SYS   = 6;
  localparam int CB_DST_SYS   = 7;
  localparam int CF_SRC_STEP  = 8;
  localparam int CF_DST_STEP  = 12;
  localparam int CF_DST_LINE  = 16;
  localparam int CF_UNIT      = 20;
  localparam int CF_SRC_LINE  = 24;

  typedef enum logic [1:0] {RG_SRC = 2'd0, RG_DST = 2'd1, RG_CNT = 2'd2, RG_CTRL = 2'd3} reg_idx_t;
  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_READ = 2'd1, SQ_WRITE = 2'd2} seq_state_t;

  typedef struct packed {
    logic unit_done;
    logic cycle_done;
    logic fin_set;
    logic err_set;
  } seq_evt_t;

  // signed per-unit address change for a step code
  function automatic logic signed [3:0] step_delta(input logic [2:0] code);
    case (code)
      3'b001:  return 4'sd1;
      3'b010:  return 4'sd2;
      3'b011:  return 4'sd4;
      3'b101:  return -4'sd1;
      3'b110:  return -4'sd2;
      3'b111:  return -4'sd4;
      default: return 4'sd0;
    endcase
  endfunction
endpackage

// File: rtl/dmac_hs.sv
module dmac_hs import dmac_pkg::*; #(
  parameter int LINES = 16,
  parameter int NW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] hs_req,
  input  logic [NW-1:0]    src_no,
  input  logic [NW-1:0]    dst_no,
  input  logic             start,
  output logic             ready,
  output logic [LINES-1:0] grant
);
  logic [LINES-1:1] grant_q;

  assign ready = ((src_no == '0) || hs_req[src_no]) &&
                 ((dst_no == '0) || hs_req[dst_no]);

  for (genvar g = 1; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) grant_q[g] <= 1'b0;
      else        grant_q[g] <= start && ((src_no == NW'(g)) || (dst_no == NW'(g)));
    end
  end

  assign grant = {grant_q, 1'b0};

  // R11: a grant never lasts more than one clock
  p_grant_one_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (grant == '0));
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs import dmac_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  seq_evt_t      evt,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] cnt,
  output logic [31:0]   ctrl
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   ctrl_q, ctrl_wr;
  logic          cnt_wr;

  function automatic logic [AW-1:0] sext(input logic signed [3:0] d);
    return {{(AW-4){d[3]}}, d};
  endfunction

  // status flags: writing 0 clears, writing 1 keeps
  always_comb begin
    ctrl_wr         = reg_wdata;
    ctrl_wr[CB_FIN] = ctrl_q[CB_FIN] & reg_wdata[CB_FIN];
    ctrl_wr[CB_ERR] = ctrl_q[CB_ERR] & reg_wdata[CB_ERR];
  end

  assign cnt_wr = reg_we && (reg_sel == RG_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (evt.unit_done) begin
        src_q <= src_q + sext(step_delta(ctrl_q[CF_SRC_STEP +: 3]));
        dst_q <= dst_q + sext(step_delta(ctrl_q[CF_DST_STEP +: 3]));
      end
      if (evt.cycle_done) cnt_q <= cnt_q - CW'(1);
      if (reg_we) begin
        case (reg_sel)
          RG_SRC:  src_q  <= reg_wdata[AW-1:0];
          RG_DST:  dst_q  <= reg_wdata[AW-1:0];
          RG_CNT:  cnt_q  <= reg_wdata[CW-1:0];
          default: ctrl_q <= ctrl_wr;
        endcase
      end
      // engine events win over a same-cycle software write
      if (evt.fin_set) begin
        ctrl_q[CB_FIN] <= 1'b1;
        ctrl_q[CB_EN]  <= 1'b0;
      end
      if (evt.err_set) begin
        ctrl_q[CB_ERR] <= 1'b1;
        ctrl_q[CB_EN]  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_sel)
      RG_SRC:  reg_rdata = 32'(src_q);
      RG_DST:  reg_rdata = 32'(dst_q);
      RG_CNT:  reg_rdata = 32'(cnt_q);
      default: reg_rdata = ctrl_q;
    endcase
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign cnt      = cnt_q;
  assign ctrl     = ctrl_q;

  p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.cycle_done && !cnt_wr) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  p_fin_drops_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fin_set |=> (ctrl_q[CB_FIN] && !ctrl_q[CB_EN]));
  p_err_keeps_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.err_set && !cnt_wr) |=> ($stable(cnt_q) && ctrl_q[CB_ERR] && !ctrl_q[CB_EN]));
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq import dmac_pkg::*; #(
  parameter int DW    = 32,
  parameter int UNITS = 4,
  parameter int UW    = $clog2(UNITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  input  logic          burst,
  input  logic          hs_ready,
  input  logic          m_ack,
  input  logic          m_err,
  input  logic [DW-1:0] m_rdata,
  output seq_evt_t      evt,
  output logic          cycle_start,
  output logic          rd_phase,
  output logic          m_req,
  output logic          m_we,
  output logic [DW-1:0] m_wdata
);
  seq_state_t    state_q;
  logic [UW-1:0] unit_q;
  logic [DW-1:0] data_q;
  logic          last_unit, idle_en;

  assign idle_en     = en && (state_q == SQ_IDLE);
  assign m_req       = en && (state_q != SQ_IDLE);
  assign m_we        = (state_q == SQ_WRITE);
  assign rd_phase    = (state_q == SQ_READ);
  assign m_wdata     = data_q;
  assign last_unit   = !burst || (unit_q == UW'(UNITS - 1));
  assign cycle_start = idle_en && !cnt_zero && hs_ready;

  always_comb begin
    evt.err_set    = m_req && m_err;
    evt.unit_done  = m_req && m_we && m_ack && !m_err;
    evt.cycle_done = evt.unit_done && last_unit;
    evt.fin_set    = (idle_en && cnt_zero) || (evt.cycle_done && cnt_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      unit_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (cycle_start) begin
          state_q <= SQ_READ;
          unit_q  <= '0;
        end
        SQ_READ: begin
          if (!en || m_err) state_q <= SQ_IDLE;
          else if (m_ack) begin
            data_q  <= m_rdata;
            state_q <= SQ_WRITE;
          end
        end
        default: begin
          if (!en || m_err) state_q <= SQ_IDLE;
          else if (m_ack) begin
            unit_q  <= unit_q + UW'(1);
            state_q <= last_unit ? SQ_IDLE : SQ_READ;
          end
        end
      endcase
    end
  end

  // R3: the unit read is the unit written next
  p_write_carries_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && m_req && m_ack && !m_err) |=> (m_we && (m_wdata == $past(m_rdata))));
  p_stop_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.err_set |=> !m_req);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine import dmac_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 24,
  parameter int LINES = 16,
  parameter int UNITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             m_req,
  output logic             m_we,
  output logic             m_sys,
  output logic [1:0]       m_size,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  input  logic [DW-1:0]    m_rdata,
  input  logic             m_ack,
  input  logic             m_err,
  input  logic [LINES-1:0] hs_req,
  output logic [LINES-1:0] hs_grant,
  output logic             irq
);
  localparam int NW = $clog2(LINES);

  seq_evt_t      evt;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] cnt;
  logic [31:0]   ctrl;
  logic          hs_ready, cycle_start, rd_phase;

  dmac_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
    .src_addr(src_addr), .dst_addr(dst_addr), .cnt(cnt), .ctrl(ctrl)
  );

  dmac_hs #(.LINES(LINES), .NW(NW)) u_hs (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req),
    .src_no(ctrl[CF_SRC_LINE +: NW]), .dst_no(ctrl[CF_DST_LINE +: NW]),
    .start(cycle_start), .ready(hs_ready), .grant(hs_grant)
  );

  dmac_seq #(.DW(DW), .UNITS(UNITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(ctrl[CB_EN]),
    .cnt_zero(cnt == '0), .cnt_last(cnt == CW'(1)), .burst(ctrl[CB_BURST]),
    .hs_ready(hs_ready), .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .evt(evt), .cycle_start(cycle_start), .rd_phase(rd_phase),
    .m_req(m_req), .m_we(m_we), .m_wdata(m_wdata)
  );

  assign m_addr = rd_phase ? src_addr : dst_addr;
  assign m_sys  = rd_phase ? ctrl[CB_SRC_SYS] : ctrl[CB_DST_SYS];
  assign m_size = ctrl[CF_UNIT +: 2];
  assign irq    = (ctrl[CB_FIN] && ctrl[CB_FIN_IE]) || (ctrl[CB_ERR] && ctrl[CB_ERR_IE]);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack && !m_err && !reg_we) |=> $stable(m_addr));
endmodule

// File: tb/sim_dma_xfer_engine.sv
`timescale 1ns/1ps
module sim_dma_xfer_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        m_req, m_we, m_sys, m_ack, m_err;
  logic [1:0]  m_size;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [15:0] hs_req = '0, hs_grant;
  logic        irq;

  always #10 clk = ~clk;

  dma_xfer_engine u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [256];
  logic [7:0] rmem [256];
  logic [7:0] ea;

  // memory model: combinational response, error at byte address F8
  assign ea = m_addr[7:0];
  always_comb begin
    m_ack = m_req && (ea != 8'hF8);
    m_err = m_req && (ea == 8'hF8);
    case (m_size)
      2'b01:   m_rdata = {16'h0, mem[8'(ea + 1)], mem[ea]};
      2'b10:   m_rdata = {24'h0, mem[ea]};
      default: m_rdata = {mem[8'(ea + 3)], mem[8'(ea + 2)], mem[8'(ea + 1)], mem[ea]};
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (m_req && m_we && m_ack) begin
      mem[ea] <= m_wdata[7:0];
      if (m_size != 2'b10) mem[8'(ea + 1)] <= m_wdata[15:8];
      if (m_size == 2'b00 || m_size == 2'b11) begin
        mem[8'(ea + 2)] <= m_wdata[23:16];
        mem[8'(ea + 3)] <= m_wdata[31:24];
      end
    end
  end

  // port monitor
  logic [1:0] exp_size = 2'd0;
  logic exp_rd_sys = 1'b0, exp_wr_sys = 1'b0;
  int mon_bad = 0, req_seen = 0, g3 = 0, g7 = 0, g_other = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_req) begin
        req_seen++;
        if (m_size != exp_size || m_sys != (m_we ? exp_wr_sys : exp_rd_sys)) mon_bad++;
      end
      for (int i = 0; i < 16; i++)
        if (hs_grant[i]) begin
          if (i == 3) g3++; else if (i == 7) g7++; else g_other++;
        end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] c;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      rd(2'd3, c);
      if (!c[0]) break;
    end
  endtask

  // bench's own unit copy: sign from bit 2, magnitude 2^(low-1)
  function automatic int step_of(input logic [2:0] code);
    int mag;
    mag = (code[1:0] == 2'b00) ? 0 : (1 << (code[1:0] - 1));
    return code[2] ? -mag : mag;
  endfunction

  task automatic ref_copy(input int units, input logic [1:0] sz, input logic [2:0] sc,
                          input logic [2:0] dc, input logic [7:0] s0, input logic [7:0] d0);
    logic [7:0] s, d;
    logic [7:0] tmp [4];
    int nb;
    s = s0; d = d0;
    nb = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 1 : 4;
    for (int u = 0; u < units; u++) begin
      for (int b = 0; b < nb; b++) tmp[b] = rmem[8'(s + 8'(b))];
      for (int b = 0; b < nb; b++) rmem[8'(d + 8'(b))] = tmp[b];
      s = 8'(int'(s) + step_of(sc));
      d = 8'(int'(d) + step_of(dc));
    end
  endtask

  task automatic mem_cmp(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== rmem[i]) bad++;
    chk(bad == 0, tag, 32'(bad), 32'd0);
  endtask

  typedef struct packed {
    logic [1:0] sz;
    logic       burst;
    logic [2:0] sc;
    logic [2:0] dc;
    logic       rs;
    logic       ws;
    logic [7:0] cnt;
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] esrc;
    logic [7:0] edst;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'b00, 1'b0, 3'b011, 3'b011, 1'b1, 1'b0, 8'd3, 8'h10, 8'h80, 8'h1C, 8'h8C},
    '{2'b01, 1'b1, 3'b010, 3'b010, 1'b0, 1'b1, 8'd2, 8'h20, 8'h90, 8'h30, 8'hA0},
    '{2'b10, 1'b0, 3'b001, 3'b111, 1'b1, 1'b1, 8'd4, 8'h40, 8'hC0, 8'h44, 8'hB0},
    '{2'b10, 1'b1, 3'b000, 3'b001, 1'b0, 1'b0, 8'd1, 8'h05, 8'hD0, 8'h05, 8'hD4},
    '{2'b00, 1'b0, 3'b111, 3'b100, 1'b1, 1'b0, 8'd2, 8'h38, 8'hE0, 8'h30, 8'hE0},
    '{2'b01, 1'b0, 3'b110, 3'b101, 1'b0, 1'b1, 8'd3, 8'h56, 8'hF0, 8'h50, 8'hED}
  };

  initial begin : watchdog
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v, c;
    for (int i = 0; i < 256; i++) rmem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(!irq && !m_req && hs_grant == 0, "R1 outputs idle", {irq, m_req, hs_grant}, 0);

    // R2 register map
    wr(2'd0, 32'hDEADBEEF); rd(2'd0, v); chk(v == 32'hDEADBEEF, "R2 source", v, 32'hDEADBEEF);
    wr(2'd1, 32'h12345678); rd(2'd1, v); chk(v == 32'h12345678, "R2 destination", v, 32'h12345678);
    wr(2'd2, 32'hFFFFFFFF); rd(2'd2, v); chk(v == 32'h00FFFFFF, "R2 24-bit count", v, 32'h00FFFFFF);
    wr(2'd3, 32'hABCDEEF0); rd(2'd3, v); chk(v == 32'hABCDEEE0, "R2/R10 control, flag not set by 1", v, 32'hABCDEEE0);
    wr(2'd3, 32'h0);

    // table walk: R3 R5 R6 R7 R4 R9 R13
    for (int t = 0; t < 6; t++) begin
      vec_t e;
      e = VEC[t];
      exp_size = e.sz; exp_rd_sys = e.rs; exp_wr_sys = e.ws;
      wr(2'd0, 32'(e.src)); wr(2'd1, 32'(e.dst)); wr(2'd2, 32'(e.cnt));
      wr(2'd3, 32'h5 | (32'(e.burst) << 3) | (32'(e.rs) << 6) | (32'(e.ws) << 7) |
               (32'(e.sc) << 8) | (32'(e.dc) << 12) | (32'(e.sz) << 20));
      wait_done();
      ref_copy(int'(e.cnt) * (e.burst ? 4 : 1), e.sz, e.sc, e.dc, e.src, e.dst);
      rd(2'd0, v); chk(v == 32'(e.esrc), $sformatf("R6/R7 vec%0d final source", t), v, 32'(e.esrc));
      rd(2'd1, v); chk(v == 32'(e.edst), $sformatf("R6/R7 vec%0d final destination", t), v, 32'(e.edst));
      rd(2'd2, v); chk(v == 0, $sformatf("R5 vec%0d count at end", t), v, 0);
      rd(2'd3, v); chk(v[1:0] == 2'b10, $sformatf("R4 vec%0d finish set, enable clear", t), 32'(v[1:0]), 2);
      chk(irq, $sformatf("R9 vec%0d finish interrupt", t), 32'(irq), 1);
      mem_cmp($sformatf("R3 vec%0d memory contents", t));
      wr(2'd3, 32'h0);
      chk(!irq, $sformatf("R10 vec%0d finish cleared by 0", t), 32'(irq), 0);
    end
    chk(mon_bad == 0, "R3/R13 size and bus side on every access", 32'(mon_bad), 0);

    // R4 zero count
    exp_size = 2'b00; exp_rd_sys = 1'b0; exp_wr_sys = 1'b0;
    wr(2'd2, 32'h0);
    req_seen = 0;
    wr(2'd3, 32'h5);
    @(negedge clk);
    rd(2'd3, v);
    chk(v[1:0] == 2'b10 && req_seen == 0, "R4 zero count finishes without access", {v[1:0], 30'(req_seen)}, 32'h80000000);
    wr(2'd3, 32'h0);

    // R11 handshake, both lines required
    g3 = 0; g7 = 0; g_other = 0; req_seen = 0;
    wr(2'd0, 32'h60); wr(2'd1, 32'h70); wr(2'd2, 32'd3);
    c = 32'h1 | (32'h3 << 8) | (32'h3 << 12) | (32'h7 << 16) | (32'h3 << 24);
    wr(2'd3, c);
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk(v == 3 && req_seen == 0, "R11 waits with no request", v, 3);
    hs_req[3] = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk(v == 3 && req_seen == 0, "R11 waits for destination line too", v, 3);
    hs_req[7] = 1'b1;
    @(negedge clk);
    hs_req = '0;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk(v == 2, "R5 count after one paced cycle", v, 2);
    chk(g3 == 1 && g7 == 1 && g_other == 0, "R11 one grant per line per cycle", 32'(g3 * 16 + g7), 32'h11);
    hs_req[3] = 1'b1; hs_req[7] = 1'b1;
    wait_done();
    hs_req = '0;
    ref_copy(3, 2'b00, 3'b011, 3'b011, 8'h60, 8'h70);
    rd(2'd2, v); chk(v == 0, "R11 paced transfer completes", v, 0);
    chk(g3 == 3 && g_other == 0, "R11 grant count over three cycles", 32'(g3), 3);
    mem_cmp("R11 paced memory contents");
    wr(2'd3, 32'h0);

    // R12 software stop
    wr(2'd2, 32'd2);
    wr(2'd3, c);
    repeat (3) @(negedge clk);
    wr(2'd3, c & ~32'h1);
    req_seen = 0;
    hs_req[3] = 1'b1; hs_req[7] = 1'b1;
    repeat (6) @(negedge clk);
    hs_req = '0;
    rd(2'd2, v);
    chk(v == 2 && req_seen == 0, "R12 stopped channel keeps count, no access", {v[15:0], 16'(req_seen)}, 32'h00020000);

    // R8 error response, R9 and R10 flag handling
    wr(2'd0, 32'hF8); wr(2'd1, 32'h70); wr(2'd2, 32'd5);
    wr(2'd3, 32'h1 | (32'h1 << 5) | (32'h3 << 8) | (32'h3 << 12));
    repeat (3) @(negedge clk);
    rd(2'd3, v); chk(v[4] && !v[0], "R8 error sets flag and drops enable", v, 32'h10);
    rd(2'd2, v); chk(v == 5, "R8 count unchanged by error", v, 5);
    chk(irq, "R9 error interrupt", 32'(irq), 1);
    req_seen = 0;
    repeat (4) @(negedge clk);
    chk(req_seen == 0, "R8 no request after error", 32'(req_seen), 0);
    wr(2'd3, 32'h30);
    rd(2'd3, v); chk(v[4] && irq, "R10 writing 1 keeps error flag", v, 32'h30);
    wr(2'd3, 32'h10);
    rd(2'd3, v); chk(v[4] && !irq, "R9 interrupt masked by enable bit", 32'(irq), 0);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk(!v[4], "R10 writing 0 clears error flag", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule